// File: doc/BRIEF.md
# Unlock-Sequence Flash Command Decoder

This block is the command front end of a word-wide parallel NOR flash. Each bus write reaches it as a one-cycle strobe carrying a 21-bit word address and 16-bit data. The decoder follows the multi-cycle unlock handshake and recognises word program, sector erase, block erase and chip erase. It also handles entry to the identification, query and security-ID read modes, and the return to array read. For each accepted operation it emits a one-cycle operation pulse with a code, the latched target address and the data word. A separate program/erase timer block consumes that pulse and reports back through the busy inputs.

Unlock cycles compare only the low 11 address bits and the low data byte. A write that breaks an unlock sequence aborts it. Three one-cycle shortcuts exist: erase suspend while an erase runs, erase resume while an erase is held, and exit to array read. A short query entry also exists. While the timers are busy, every write is ignored except erase suspend. When the write-protect input is low, program and erase aimed at the protected 8K-word boot region are dropped silently, and chip erase is dropped entirely.

The sequencer has these states:
- SEQ_IDLE: waiting for a command.
- SEQ_KEY1: the first key has been seen.
- SEQ_KEY2: the second key has been seen, and the next write is the command cycle.
- SEQ_PROG_ARM: waiting for the program address and data.
- SEQ_ERS_ARM: erase setup has been seen.
- SEQ_ERS_KEY1 and SEQ_ERS_KEY2: the repeated keys of an erase.

The transitions are:
- SEQ_IDLE to SEQ_KEY1 on AAh at 555h.
- SEQ_KEY1 to SEQ_KEY2 on 55h at 2AAh.
- SEQ_KEY2 to SEQ_PROG_ARM on A0h.
- SEQ_KEY2 to SEQ_ERS_ARM on 80h.
- SEQ_KEY2 to SEQ_IDLE on a mode command.
- SEQ_PROG_ARM to SEQ_IDLE on any write, which issues the program.
- SEQ_ERS_ARM to SEQ_ERS_KEY1 on AAh at 555h.
- SEQ_ERS_KEY1 to SEQ_ERS_KEY2 on 55h at 2AAh.
- SEQ_ERS_KEY2 to SEQ_IDLE on the final erase code.
- Any key state to SEQ_IDLE on a mismatch (abort).

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, op_valid is 0 and mode is 0 (array read).
- R2: A program is four writes: AAh@555h, then 55h@2AAh, then A0h@555h, then the target. Any write in SEQ_PROG_ARM is taken as the target. In the cycle after the fourth write, op_valid pulses with op_code 1, op_addr equal to that write's address and op_data equal to its data.
- R3: An erase is five prefix writes: AAh@555h, then 55h@2AAh, then 80h@555h, then AAh@555h, then 55h@2AAh. A final 50h at any address gives op_code 2 (sector). A final 30h gives op_code 3 (block). A final 10h at 555h gives op_code 4 (chip). In each case op_addr is the final write's address.
- R4: Key and command matching uses only address bits 10..0 and data bits 7..0. Address bits 20..11 and data bits 15..8 of command cycles have no effect.
- R5: A mismatching write in SEQ_KEY1, SEQ_KEY2, SEQ_ERS_ARM, SEQ_ERS_KEY1 or SEQ_ERS_KEY2 aborts the sequence. An unknown final erase code, or 10h away from 555h, also aborts it. An abort returns to SEQ_IDLE with no op and sets mode to 0. A fresh sequence then decodes normally.
- R6: The third cycle at 555h enters a read mode: 90h gives mode 1 (ID), 98h gives mode 2 (query) and 88h gives mode 3 (security ID). A single 98h at 055h from SEQ_IDLE also gives mode 2.
- R7: A single F0h at any address from SEQ_IDLE sets mode to 0, and so does F0h as the third unlock cycle. While busy is high, the exit is ignored.
- R8: While busy is high, writes produce no op and no mode change. The one exception is B0h at any address with busy_erase high, which gives op_code 5 (suspend). With busy low and erase_held high, a single 30h at any address gives op_code 6 (resume).
- R9: With wp_n low, program, sector erase and block erase whose target lies in the protected region produce no op. With PROT_TOP=1 that region is 1FE000h-1FFFFFh; with PROT_TOP=0 it is 000000h-001FFFh. Chip erase also produces no op. Targets outside the region, and all targets with wp_n high, are issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | One-cycle bus write strobe |
| wr_addr | input | 21 | Word address of the write |
| wr_data | input | 16 | Data of the write |
| wp_n | input | 1 | Write-protect, low protects the boot region |
| busy | input | 1 | Program or erase in progress |
| busy_erase | input | 1 | The busy operation is an erase |
| erase_held | input | 1 | An erase is suspended |
| op_valid | output | 1 | One-cycle operation pulse |
| op_code | output | 3 | 1 program, 2 sector, 3 block, 4 chip, 5 suspend, 6 resume |
| op_addr | output | 21 | Target address of the operation |
| op_data | output | 16 | Data word of the operation |
| mode | output | 2 | 0 array, 1 ID, 2 query, 3 security ID |

## Verification
Several properties are checked on every cycle by assertions:
- An operation pulse always follows a write.
- A busy write never yields an op or a mode change, suspend excepted.
- Suspend only issues during a busy erase.
- No protected-region program or erase, and no chip erase, leaves the block while wp_n was low.

The full handshake cannot be seen cycle by cycle, so the bench scenarios show it. These cover the exact cycle order, the abort paths and the mode entries and exits. They also show that random noise in the upper address and data bits is ignored, and that random program and erase traffic under a random write-protect setting matches the bench's own region model.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int KEY_ADDR_W = 11;
    localparam int CMD_W      = 8;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_KEY1,
        SEQ_KEY2,
        SEQ_PROG_ARM,
        SEQ_ERS_ARM,
        SEQ_ERS_KEY1,
        SEQ_ERS_KEY2
    } seq_state_e;

    typedef enum logic [2:0] {
        OP_NONE         = 3'd0,
        OP_PROGRAM      = 3'd1,
        OP_SECTOR_ERASE = 3'd2,
        OP_BLOCK_ERASE  = 3'd3,
        OP_CHIP_ERASE   = 3'd4,
        OP_SUSPEND      = 3'd5,
        OP_RESUME       = 3'd6
    } op_kind_e;

    typedef enum logic [1:0] {
        MODE_ARRAY = 2'd0,
        MODE_ID    = 2'd1,
        MODE_QUERY = 2'd2,
        MODE_SECID = 2'd3
    } rd_mode_e;

    localparam logic [KEY_ADDR_W-1:0] ADR_KEY_A       = 11'h555;
    localparam logic [KEY_ADDR_W-1:0] ADR_KEY_B       = 11'h2AA;
    localparam logic [KEY_ADDR_W-1:0] ADR_QUERY_SHORT = 11'h055;

    localparam logic [CMD_W-1:0] CMD_KEY_A       = 8'hAA;
    localparam logic [CMD_W-1:0] CMD_KEY_B       = 8'h55;
    localparam logic [CMD_W-1:0] CMD_PROGRAM     = 8'hA0;
    localparam logic [CMD_W-1:0] CMD_ERASE_SETUP = 8'h80;
    localparam logic [CMD_W-1:0] CMD_SECTOR      = 8'h50;
    localparam logic [CMD_W-1:0] CMD_BLOCK       = 8'h30;
    localparam logic [CMD_W-1:0] CMD_CHIP        = 8'h10;
    localparam logic [CMD_W-1:0] CMD_ENTER_ID    = 8'h90;
    localparam logic [CMD_W-1:0] CMD_ENTER_QUERY = 8'h98;
    localparam logic [CMD_W-1:0] CMD_ENTER_SECID = 8'h88;
    localparam logic [CMD_W-1:0] CMD_EXIT        = 8'hF0;
    localparam logic [CMD_W-1:0] CMD_SUSPEND     = 8'hB0;
    localparam logic [CMD_W-1:0] CMD_RESUME      = 8'h30;

endpackage

// File: rtl/flash_key_match.sv
module flash_key_match
    import flash_cmd_pkg::*;
(
    input  logic [KEY_ADDR_W-1:0] addr_lo,
    input  logic [CMD_W-1:0]      cmd,
    output logic                  key_a,
    output logic                  key_b,
    output logic                  at_key_addr,
    output logic                  at_query_short
);

    // Only the low address bits and the low data byte take part (R4)
    always_comb begin
        at_key_addr    = (addr_lo == ADR_KEY_A);
        at_query_short = (addr_lo == ADR_QUERY_SHORT);
        key_a          = at_key_addr && (cmd == CMD_KEY_A);
        key_b          = (addr_lo == ADR_KEY_B) && (cmd == CMD_KEY_B);
    end

endmodule

// File: rtl/flash_prot_region.sv
module flash_prot_region #(
    parameter int HI_W     = 8,
    parameter bit PROT_TOP = 1'b1
) (
    input  logic [HI_W-1:0] addr_hi,
    output logic            in_region
);

    generate
        if (PROT_TOP) begin : g_top
            assign in_region = &addr_hi;
        end else begin : g_bottom
            assign in_region = ~|addr_hi;
        end
    endgenerate

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W     = 21,
    parameter int DATA_W     = 16,
    parameter int PROT_WORDS = 8192,
    parameter bit PROT_TOP   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wp_n,
    input  logic              busy,
    input  logic              busy_erase,
    input  logic              erase_held,
    output logic              op_valid,
    output logic [2:0]        op_code,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic [1:0]        mode
);

    localparam int PROT_BITS = $clog2(PROT_WORDS);
    localparam int HI_W      = ADDR_W - PROT_BITS;

    seq_state_e state_q, state_d;
    rd_mode_e   mode_q, mode_d;
    op_kind_e   kind;
    logic       fire;

    logic [CMD_W-1:0] cmd;
    logic key_a, key_b, at_key_addr, at_query_short;
    logic wr_in_region, blocked, op_in_region;

    assign cmd = wr_data[CMD_W-1:0];

    flash_key_match u_match (
        .addr_lo        (wr_addr[KEY_ADDR_W-1:0]),
        .cmd            (cmd),
        .key_a          (key_a),
        .key_b          (key_b),
        .at_key_addr    (at_key_addr),
        .at_query_short (at_query_short)
    );

    flash_prot_region #(.HI_W(HI_W), .PROT_TOP(PROT_TOP)) u_wr_region (
        .addr_hi   (wr_addr[ADDR_W-1:PROT_BITS]),
        .in_region (wr_in_region)
    );

    assign blocked = !wp_n && wr_in_region;

    // Next-state and decode
    always_comb begin
        state_d = state_q;
        mode_d  = mode_q;
        fire    = 1'b0;
        kind    = OP_NONE;
        if (wr_valid) begin
            if (busy) begin
                if (busy_erase && cmd == CMD_SUSPEND) begin
                    fire = 1'b1;
                    kind = OP_SUSPEND;
                end
            end else begin
                unique case (state_q)
                    SEQ_IDLE: begin
                        if (key_a) begin
                            state_d = SEQ_KEY1;
                        end else if (cmd == CMD_EXIT) begin
                            mode_d = MODE_ARRAY;
                        end else if (at_query_short && cmd == CMD_ENTER_QUERY) begin
                            mode_d = MODE_QUERY;
                        end else if (erase_held && cmd == CMD_RESUME) begin
                            fire = 1'b1;
                            kind = OP_RESUME;
                        end
                    end
                    SEQ_KEY1: begin
                        if (key_b) begin
                            state_d = SEQ_KEY2;
                        end else begin
                            state_d = SEQ_IDLE;
                            mode_d  = MODE_ARRAY;
                        end
                    end
                    SEQ_KEY2: begin
                        state_d = SEQ_IDLE;
                        if (!at_key_addr) begin
                            mode_d = MODE_ARRAY;
                        end else begin
                            case (cmd)
                                CMD_PROGRAM:     state_d = SEQ_PROG_ARM;
                                CMD_ERASE_SETUP: state_d = SEQ_ERS_ARM;
                                CMD_ENTER_ID:    mode_d  = MODE_ID;
                                CMD_ENTER_QUERY: mode_d  = MODE_QUERY;
                                CMD_ENTER_SECID: mode_d  = MODE_SECID;
                                default:         mode_d  = MODE_ARRAY;
                            endcase
                        end
                    end
                    SEQ_PROG_ARM: begin
                        state_d = SEQ_IDLE;
                        if (!blocked) begin
                            fire = 1'b1;
                            kind = OP_PROGRAM;
                        end
                    end
                    SEQ_ERS_ARM: begin
                        if (key_a) begin
                            state_d = SEQ_ERS_KEY1;
                        end else begin
                            state_d = SEQ_IDLE;
                            mode_d  = MODE_ARRAY;
                        end
                    end
                    SEQ_ERS_KEY1: begin
                        if (key_b) begin
                            state_d = SEQ_ERS_KEY2;
                        end else begin
                            state_d = SEQ_IDLE;
                            mode_d  = MODE_ARRAY;
                        end
                    end
                    SEQ_ERS_KEY2: begin
                        state_d = SEQ_IDLE;
                        if (cmd == CMD_SECTOR) begin
                            fire = !blocked;
                            kind = OP_SECTOR_ERASE;
                        end else if (cmd == CMD_BLOCK) begin
                            fire = !blocked;
                            kind = OP_BLOCK_ERASE;
                        end else if (cmd == CMD_CHIP && at_key_addr) begin
                            fire = wp_n;
                            kind = OP_CHIP_ERASE;
                        end else begin
                            mode_d = MODE_ARRAY;
                        end
                    end
                    default: state_d = SEQ_IDLE;
                endcase
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            mode_q  <= MODE_ARRAY;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_valid <= 1'b0;
            op_code  <= OP_NONE;
            op_addr  <= '0;
            op_data  <= '0;
        end else begin
            op_valid <= fire;
            if (fire) begin
                op_code <= kind;
                op_addr <= wr_addr;
                op_data <= wr_data;
            end
        end
    end

    assign mode = mode_q;

    // Region check of the issued address, for the protection assertion
    flash_prot_region #(.HI_W(HI_W), .PROT_TOP(PROT_TOP)) u_op_region (
        .addr_hi   (op_addr[ADDR_W-1:PROT_BITS]),
        .in_region (op_in_region)
    );

    assert_op_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> $past(wr_valid));

    assert_op_code_known_R2: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> (op_code != OP_NONE && op_code <= OP_RESUME));

    assert_busy_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_valid && !(busy_erase && wr_data[CMD_W-1:0] == CMD_SUSPEND))
        |=> (!op_valid && $stable(mode)));

    assert_suspend_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_SUSPEND) |-> $past(busy && busy_erase));

    assert_prot_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !$past(wp_n) &&
         (op_code == OP_PROGRAM || op_code == OP_SECTOR_ERASE || op_code == OP_BLOCK_ERASE))
        |-> !op_in_region);

    assert_chip_wp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_CHIP_ERASE) |-> $past(wp_n));

endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [20:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        wp_n = 1'b1;
    logic        busy = 1'b0;
    logic        busy_erase = 1'b0;
    logic        erase_held = 1'b0;
    logic        op_valid;
    logic [2:0]  op_code;
    logic [20:0] op_addr;
    logic [15:0] op_data;
    logic [1:0]  mode;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    flash_cmd_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .wp_n(wp_n), .busy(busy), .busy_erase(busy_erase),
        .erase_held(erase_held), .op_valid(op_valid), .op_code(op_code),
        .op_addr(op_addr), .op_data(op_data), .mode(mode)
    );

    // Bench model of the protected top region
    function automatic bit in_top(input logic [20:0] a);
        return a[20:13] == 8'hFF;
    endfunction

    // Command-cycle address/data with random noise in the ignored bits
    function automatic logic [20:0] ka(input logic [10:0] lo);
        logic [9:0] hi = 10'($urandom());
        return {hi, lo};
    endfunction

    function automatic logic [15:0] kd(input logic [7:0] lo);
        logic [7:0] hi = 8'($urandom());
        return {hi, lo};
    endfunction

    task automatic wr(input logic [20:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_op(input string tag, input bit ev, input logic [2:0] ec,
                            input logic [20:0] ea, input logic [15:0] ed);
        check({tag, " valid"}, op_valid, ev);
        if (ev && op_valid) begin
            check({tag, " code"}, op_code, ec);
            check({tag, " addr"}, op_addr, ea);
            check({tag, " data"}, op_data, ed);
        end
    endtask

    task automatic keys3(input logic [7:0] c);
        wr(ka(11'h555), kd(8'hAA));
        wr(ka(11'h2AA), kd(8'h55));
        wr(ka(11'h555), kd(c));
    endtask

    task automatic prog(input logic [20:0] a, input logic [15:0] d);
        keys3(8'hA0);
        wr(a, d);
    endtask

    task automatic erase_prefix();
        keys3(8'h80);
        wr(ka(11'h555), kd(8'hAA));
        wr(ka(11'h2AA), kd(8'h55));
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [20:0] a;
        logic [15:0] d;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 reset op_valid", op_valid, 0);
        check("R1 reset mode", mode, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 program
        prog(21'h012345, 16'hBEEF);
        check_op("R2 program", 1, 3'd1, 21'h012345, 16'hBEEF);
        @(negedge clk);
        check("R2 pulse one cycle", op_valid, 0);

        // R3 erases
        erase_prefix(); wr(21'h123456, kd(8'h50));
        check_op("R3 sector", 1, 3'd2, 21'h123456, wr_data);
        erase_prefix(); wr(21'h0A8000, kd(8'h30));
        check_op("R3 block", 1, 3'd3, 21'h0A8000, wr_data);
        a = ka(11'h555);
        erase_prefix(); wr(a, kd(8'h10));
        check_op("R3 chip", 1, 3'd4, a, wr_data);

        // R5 aborts
        erase_prefix(); wr(21'h000556, kd(8'h10));
        check_op("R5 chip off-key abort", 0, 0, 0, 0);
        erase_prefix(); wr(21'h000100, kd(8'h20));
        check_op("R5 unknown final code", 0, 0, 0, 0);
        keys3(8'h90);
        check("R6 enter ID", mode, 1);
        wr(ka(11'h555), kd(8'hAA));
        wr(ka(11'h2AB), kd(8'h55));
        check("R5 abort to array mode", mode, 0);
        prog(21'h000010, 16'h1234);
        check_op("R5 fresh sequence after abort", 1, 3'd1, 21'h000010, 16'h1234);

        // R6 entries
        keys3(8'h98);
        check("R6 enter query", mode, 2);
        keys3(8'h88);
        check("R6 enter security ID", mode, 3);
        wr(ka(11'h055), kd(8'h98));
        check("R6 R4 short query entry", mode, 2);

        // R7 exit
        wr(21'($urandom()), kd(8'hF0));
        check("R7 single exit", mode, 0);
        keys3(8'h90);
        keys3(8'hF0);
        check("R7 three-cycle exit", mode, 0);
        keys3(8'h90);
        busy = 1'b1;
        wr(21'h000000, 16'h00F0);
        check("R7 exit ignored while busy", mode, 1);

        // R8 busy filtering
        prog(21'h000020, 16'h5555);
        check_op("R8 program ignored while busy", 0, 0, 0, 0);
        check("R8 mode held while busy", mode, 1);
        wr(21'h003000, 16'h00B0);
        check_op("R8 suspend needs erase", 0, 0, 0, 0);
        busy_erase = 1'b1;
        wr(21'h003000, 16'h00B0);
        check_op("R8 suspend", 1, 3'd5, 21'h003000, 16'h00B0);
        busy = 1'b0; busy_erase = 1'b0;
        wr(ka(11'h555), kd(8'hF0));
        check("R7 exit after busy", mode, 0);
        wr(21'h000777, 16'h0030);
        check_op("R8 resume needs held erase", 0, 0, 0, 0);
        erase_held = 1'b1;
        wr(21'h000777, 16'h0030);
        check_op("R8 resume", 1, 3'd6, 21'h000777, 16'h0030);
        erase_held = 1'b0;

        // R9 protection
        wp_n = 1'b0;
        prog(21'h1FF000, 16'h0001);
        check_op("R9 protected program dropped", 0, 0, 0, 0);
        prog(21'h1FDFFF, 16'h0002);
        check_op("R9 program below region", 1, 3'd1, 21'h1FDFFF, 16'h0002);
        erase_prefix(); wr(21'h1FE800, kd(8'h50));
        check_op("R9 protected sector dropped", 0, 0, 0, 0);
        erase_prefix(); wr(ka(11'h555), kd(8'h10));
        check_op("R9 chip dropped", 0, 0, 0, 0);
        wp_n = 1'b1;
        prog(21'h1FFFFF, 16'h0003);
        check_op("R9 program with wp_n high", 1, 3'd1, 21'h1FFFFF, 16'h0003);

        // Random traffic: R2 R3 R4 R9
        for (int i = 0; i < 200; i++) begin
            int kind = $urandom_range(0, 3);
            bit exp_v;
            a = ($urandom_range(0, 1) != 0) ? {8'hFF, 13'($urandom())} : 21'($urandom());
            d = 16'($urandom());
            wp_n = ($urandom_range(0, 1) != 0);
            exp_v = wp_n || !in_top(a);
            if (kind == 0) begin
                prog(a, d);
                check_op("R2 R4 R9 random program", exp_v, 3'd1, a, d);
            end else if (kind == 1) begin
                erase_prefix(); wr(a, kd(8'h50));
                check_op("R3 R4 R9 random sector", exp_v, 3'd2, a, wr_data);
            end else if (kind == 2) begin
                erase_prefix(); wr(a, kd(8'h30));
                check_op("R3 R4 R9 random block", exp_v, 3'd3, a, wr_data);
            end else begin
                logic [7:0] c;
                do c = 8'($urandom()); while (c == 8'hAA || c == 8'hF0 || c == 8'h98);
                wr(a, kd(c));
                check_op("R4 random noise write", 0, 0, 0, 0);
                check("R4 noise leaves mode", mode, 0);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule